// File: doc/BRIEF.md
# Power Button On/Off Controller

This block conditions a single external push-button input and turns it into a system power request. The raw button is synchronised and debounced, then decoded according to a selectable trigger mode. The mode can be a level of either polarity, a rising edge, a falling edge or any edge. The decoded press drives a small on/off state machine. While the system is off, a press held for the selected turn-on delay raises the power request. While it is on, a press held past the selected long-press timeout drops the request and records an emergency shutdown. A shorter press only records a power-off request, which software can act on.

All timing runs on a 32768 Hz tick enable, and each millisecond or second setting is converted to a tick count from the `TICK_HZ` parameter. Three sticky status flags are cleared by writing one: button event, emergency off and power-off request. The button-event flag drives an interrupt output that software can mask. Software can also force the power request off, gate it with an enable, or hold it on with an override.

Top module: `pwr_button_ctrl`

## Requirements
- R1: `btn_level_o` takes a new value of the synchronised button only after the button has differed from it for the debounce time selected by `db_sel`: 0 = 50 ms, 1 = 100 ms, 2 = 500 ms, 3 = none. A shorter glitch never reaches it. It resets to 0.
- R2: `trig_sel` decodes the debounced level as follows:
  - 0: active low.
  - 1: active high.
  - 2: rising edge.
  - 3: falling edge.
  - 4 to 7: any edge.
  A level mode reports an event on every cycle the level is active. An edge mode reports one event per matching transition. The held press used for timing is a low level in modes 0 and 3 and a high level otherwise.
- R3: A button event sets `flag_bi_o`. `irq_o` is `flag_bi_o` gated by `irq_en`.
- R4: In the off state, a press held for the turn-on time selected by `on_sel` raises the request. The codes are 0 = 500 ms, 1 = 50 ms, 2 = 100 ms and 3 = immediate. A shorter press leaves the system off. After turning on, the button must be released before a new press is timed.
- R5: While on, a press held for the long-press time selected by `lp_sel` drops the request and sets `flag_eo_o`. The codes are 0 = 5 s, 1 = 10 s, 2 = 15 s and 3 = disabled.
- R6: While on, a press released before the long-press timeout sets `flag_spo_o`, and the request stays high.
- R7: `force_off` drives the request low at once and returns the machine to off. After `force_off` is released, the machine stays off until a new press is timed.
- R8: `pwr_req_o` is high when `force_off` is low and either `req_ovr` is high, or `req_en` is high and the machine is on.
- R9: The flags are write-one-to-clear through `flag_clr`: bit 0 = button event, bit 1 = emergency off, bit 2 = power-off request. A set in the same cycle wins over a clear.
- R10: After reset the machine is off, and all flags and `btn_level_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 32768 Hz timing enable, one cycle wide |
| btn_i | input | 1 | Raw button input |
| trig_sel | input | 3 | Trigger mode |
| db_sel | input | 2 | Debounce time select |
| lp_sel | input | 2 | Long-press timeout select |
| on_sel | input | 2 | Turn-on delay select |
| irq_en | input | 1 | Button interrupt enable |
| force_off | input | 1 | Force power request off |
| req_en | input | 1 | Power request output enable |
| req_ovr | input | 1 | Power request override |
| flag_clr | input | 3 | Write-one-to-clear strobes for the flags |
| btn_level_o | output | 1 | Debounced button level |
| flag_bi_o | output | 1 | Button event flag |
| flag_eo_o | output | 1 | Emergency-off flag |
| flag_spo_o | output | 1 | Power-off request flag |
| irq_o | output | 1 | Masked button interrupt |
| pwr_req_o | output | 1 | Power-on request |

## Verification
The bench targets the following corner cases:
- A 20-cycle glitch under a 50 ms debounce: a design that skipped the debounce would pass it through to the level and to the flags.
- A turn-on press that is too short: an early compare would wrongly power the system.
- A long press held past 15 s with the timeout disabled: a missing disable would shut the system down.
- A hold that continues after turn-on: if the release-before-retime rule were missing, that hold would be counted again.
- Each edge mode with the flag cleared while the button is still held: a level-style decode would re-set the flag.
- A clear that collides with an active-level event: the set must win.
- Force-off with the button still pressed.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

  typedef enum logic [1:0] {
    PS_OFF     = 2'd0,
    PS_OFF_REL = 2'd1,
    PS_ON_REL  = 2'd2,
    PS_ON      = 2'd3
  } pwr_state_e;

  function automatic int unsigned to_ticks(input int unsigned ms, input int unsigned hz);
    longint unsigned prod;
    prod = longint'(ms) * longint'(hz);
    return int'(prod / 1000);
  endfunction

  function automatic int unsigned debounce_ms(input logic [1:0] sel);
    case (sel)
      2'd0:    return 50;
      2'd1:    return 100;
      2'd2:    return 500;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned turn_on_ms(input logic [1:0] sel);
    case (sel)
      2'd0:    return 500;
      2'd1:    return 50;
      2'd2:    return 100;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned long_press_ms(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5000;
      2'd1:    return 10000;
      2'd2:    return 15000;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/pbc_debounce.sv
module pbc_debounce
  import pbc_pkg::*;
#(
  parameter int TICK_HZ     = 32768,
  parameter int SYNC_STAGES = 2,
  parameter int CW          = 19
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       din,
  input  logic [1:0] db_sel,
  output logic       lvl
);

  localparam logic [CW-1:0] LIM0 = CW'(to_ticks(debounce_ms(2'd0), TICK_HZ));
  localparam logic [CW-1:0] LIM1 = CW'(to_ticks(debounce_ms(2'd1), TICK_HZ));
  localparam logic [CW-1:0] LIM2 = CW'(to_ticks(debounce_ms(2'd2), TICK_HZ));

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl_q, lvl_n;
  logic [CW-1:0]          cnt_q, cnt_n;
  logic [CW-1:0]          lim;
  logic                   s;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= (g == 0) ? din : sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign s = sync_q[SYNC_STAGES-1];

  always_comb begin
    case (db_sel)
      2'd0:    lim = LIM0;
      2'd1:    lim = LIM1;
      2'd2:    lim = LIM2;
      default: lim = '0;
    endcase
  end

  always_comb begin
    lvl_n = lvl_q;
    cnt_n = cnt_q;
    if (s == lvl_q) begin
      cnt_n = '0;
    end else if (lim == '0) begin
      lvl_n = s;
    end else if (tick) begin
      if (cnt_q + CW'(1) >= lim) begin
        lvl_n = s;
        cnt_n = '0;
      end else begin
        cnt_n = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_n;
      cnt_q <= cnt_n;
    end
  end

  assign lvl = lvl_q;

  AST_LVL_HOLDS_WHEN_MATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (s == lvl_q) |=> $stable(lvl_q)); // R1

endmodule

// File: rtl/pbc_trigger.sv
module pbc_trigger (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  logic [2:0] trig_sel,
  output logic       pressed,
  output logic       evt
);

  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  always_comb begin
    pressed = (trig_sel == 3'd0 || trig_sel == 3'd3) ? !lvl : lvl;
    case (trig_sel)
      3'd0:    evt = !lvl;
      3'd1:    evt = lvl;
      3'd2:    evt = lvl & !lvl_q;
      3'd3:    evt = !lvl & lvl_q;
      default: evt = lvl ^ lvl_q;
    endcase
  end

  AST_EDGE_EVENT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_sel >= 3'd2 && evt) |-> (lvl != $past(lvl))); // R2

endmodule

// File: rtl/pbc_power_fsm.sv
module pbc_power_fsm
  import pbc_pkg::*;
#(
  parameter int TICK_HZ = 32768,
  parameter int CW      = 19
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       pressed,
  input  logic [1:0] on_sel,
  input  logic [1:0] lp_sel,
  input  logic       force_off,
  output logic       pwr_on,
  output logic       eo_set,
  output logic       spo_set
);

  localparam logic [CW-1:0] ON0 = CW'(to_ticks(turn_on_ms(2'd0), TICK_HZ));
  localparam logic [CW-1:0] ON1 = CW'(to_ticks(turn_on_ms(2'd1), TICK_HZ));
  localparam logic [CW-1:0] ON2 = CW'(to_ticks(turn_on_ms(2'd2), TICK_HZ));
  localparam logic [CW-1:0] LP0 = CW'(to_ticks(long_press_ms(2'd0), TICK_HZ));
  localparam logic [CW-1:0] LP1 = CW'(to_ticks(long_press_ms(2'd1), TICK_HZ));
  localparam logic [CW-1:0] LP2 = CW'(to_ticks(long_press_ms(2'd2), TICK_HZ));

  pwr_state_e    st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          held_q, held_n;
  logic [CW-1:0] on_lim, lp_lim;
  logic          lp_en;
  logic          cnt_full;

  always_comb begin
    case (on_sel)
      2'd0:    on_lim = ON0;
      2'd1:    on_lim = ON1;
      2'd2:    on_lim = ON2;
      default: on_lim = '0;
    endcase
    lp_en = (lp_sel != 2'd3);
    case (lp_sel)
      2'd0:    lp_lim = LP0;
      2'd1:    lp_lim = LP1;
      default: lp_lim = LP2;
    endcase
  end

  assign cnt_full = &cnt_q;

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    eo_set  = 1'b0;
    spo_set = 1'b0;
    if (force_off) begin
      st_n  = PS_OFF_REL;
      cnt_n = '0;
    end else begin
      case (st_q)
        PS_OFF: begin
          if (!pressed) begin
            cnt_n = '0;
          end else if (cnt_q >= on_lim) begin
            st_n  = PS_ON_REL;
            cnt_n = '0;
          end else if (tick && !cnt_full) begin
            cnt_n = cnt_q + CW'(1);
          end
        end
        PS_OFF_REL: begin
          cnt_n = '0;
          if (!pressed) st_n = PS_OFF;
        end
        PS_ON_REL: begin
          cnt_n = '0;
          if (!pressed) st_n = PS_ON;
        end
        default: begin
          if (!pressed) begin
            cnt_n   = '0;
            spo_set = held_q;
          end else if (lp_en && cnt_q >= lp_lim) begin
            st_n   = PS_OFF_REL;
            cnt_n  = '0;
            eo_set = 1'b1;
          end else if (tick && !cnt_full) begin
            cnt_n = cnt_q + CW'(1);
          end
        end
      endcase
    end
    held_n = (st_q == PS_ON) && pressed && (st_n == PS_ON);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_OFF;
      cnt_q  <= '0;
      held_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      held_q <= held_n;
    end
  end

  assign pwr_on = (st_q == PS_ON) || (st_q == PS_ON_REL);

  AST_OFF_NEEDS_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_OFF && !pressed && !force_off) |=> (st_q == PS_OFF)); // R4
  AST_FORCE_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> !pwr_on); // R7
  AST_EO_LEAVES_ON: assert property (@(posedge clk) disable iff (!rst_n)
    eo_set |=> (st_q == PS_OFF_REL)); // R5
  AST_SPO_KEEPS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    spo_set |=> pwr_on); // R6

endmodule

// File: rtl/pwr_button_ctrl.sv
module pwr_button_ctrl #(
  parameter int TICK_HZ     = 32768,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       btn_i,
  input  logic [2:0] trig_sel,
  input  logic [1:0] db_sel,
  input  logic [1:0] lp_sel,
  input  logic [1:0] on_sel,
  input  logic       irq_en,
  input  logic       force_off,
  input  logic       req_en,
  input  logic       req_ovr,
  input  logic [2:0] flag_clr,
  output logic       btn_level_o,
  output logic       flag_bi_o,
  output logic       flag_eo_o,
  output logic       flag_spo_o,
  output logic       irq_o,
  output logic       pwr_req_o
);

  localparam int CW = $clog2(15 * TICK_HZ + 1);

  logic lvl, pressed, evt, pwr_on, eo_set, spo_set;
  logic bi_q, eo_q, spo_q;
  logic bi_n, eo_n, spo_n;

  pbc_debounce #(.TICK_HZ(TICK_HZ), .SYNC_STAGES(SYNC_STAGES), .CW(CW)) u_deb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .din(btn_i), .db_sel(db_sel), .lvl(lvl)
  );

  pbc_trigger u_trig (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .trig_sel(trig_sel),
    .pressed(pressed), .evt(evt)
  );

  pbc_power_fsm #(.TICK_HZ(TICK_HZ), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pressed(pressed),
    .on_sel(on_sel), .lp_sel(lp_sel), .force_off(force_off),
    .pwr_on(pwr_on), .eo_set(eo_set), .spo_set(spo_set)
  );

  always_comb begin
    bi_n  = (bi_q  & ~flag_clr[0]) | evt;
    eo_n  = (eo_q  & ~flag_clr[1]) | eo_set;
    spo_n = (spo_q & ~flag_clr[2]) | spo_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bi_q  <= 1'b0;
      eo_q  <= 1'b0;
      spo_q <= 1'b0;
    end else begin
      bi_q  <= bi_n;
      eo_q  <= eo_n;
      spo_q <= spo_n;
    end
  end

  assign btn_level_o = lvl;
  assign flag_bi_o   = bi_q;
  assign flag_eo_o   = eo_q;
  assign flag_spo_o  = spo_q;
  assign irq_o       = bi_q & irq_en;
  assign pwr_req_o   = !force_off && (req_ovr || (req_en && pwr_on));

  AST_CLEAR_WITHOUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[0] && !evt) |=> !flag_bi_o); // R9
  AST_EO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_eo_o && !flag_clr[1]) |=> flag_eo_o); // R9

endmodule

// File: tb/pwr_button_ctrl_test.sv
module pwr_button_ctrl_test;

  localparam int HZ = 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       btn_i = 1'b0;
  logic [2:0] trig_sel = 3'd1;
  logic [1:0] db_sel = 2'd3;
  logic [1:0] lp_sel = 2'd1;
  logic [1:0] on_sel = 2'd3;
  logic       irq_en = 1'b1;
  logic       force_off = 1'b0;
  logic       req_en = 1'b1;
  logic       req_ovr = 1'b0;
  logic [2:0] flag_clr = 3'd0;
  logic btn_level_o, flag_bi_o, flag_eo_o, flag_spo_o, irq_o, pwr_req_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  pwr_button_ctrl #(.TICK_HZ(HZ)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .btn_i(btn_i), .trig_sel(trig_sel),
    .db_sel(db_sel), .lp_sel(lp_sel), .on_sel(on_sel), .irq_en(irq_en),
    .force_off(force_off), .req_en(req_en), .req_ovr(req_ovr), .flag_clr(flag_clr),
    .btn_level_o(btn_level_o), .flag_bi_o(flag_bi_o), .flag_eo_o(flag_eo_o),
    .flag_spo_o(flag_spo_o), .irq_o(irq_o), .pwr_req_o(pwr_req_o)
  );

  always #10 clk = ~clk;

  int tcnt = 0;
  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 4;
    tick = (tcnt != 3);
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, cycle accurate
  int m_s1, m_s2, m_lvl, m_lq, m_dcnt, m_st, m_pcnt, m_held, m_bi, m_eo, m_spo;
  // m_st: 0 off, 1 off waiting release, 2 on waiting release, 3 on

  function automatic int ms_of(input int kind, input int sel);
    int dbt[4] = '{50, 100, 500, 0};
    int ont[4] = '{500, 50, 100, 0};
    int lpt[4] = '{5000, 10000, 15000, 0};
    if (kind == 0) return dbt[sel] * HZ / 1000;
    if (kind == 1) return ont[sel] * HZ / 1000;
    return lpt[sel] * HZ / 1000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_lvl = 0; m_lq = 0; m_dcnt = 0; m_st = 0;
      m_pcnt = 0; m_held = 0; m_bi = 0; m_eo = 0; m_spo = 0;
    end else begin
      int pr, ev, lvl_n, dcnt_n, st_n, pcnt_n, eo_s, spo_s, lim;
      pr = (trig_sel == 0 || trig_sel == 3) ? !m_lvl : m_lvl;
      case (trig_sel)
        0: ev = !m_lvl;
        1: ev = m_lvl;
        2: ev = m_lvl && !m_lq;
        3: ev = !m_lvl && m_lq;
        default: ev = (m_lvl != m_lq);
      endcase
      lvl_n = m_lvl; dcnt_n = m_dcnt;
      lim = ms_of(0, db_sel);
      if (m_s2 == m_lvl) dcnt_n = 0;
      else if (lim == 0) lvl_n = m_s2;
      else if (tick) begin
        if (m_dcnt + 1 >= lim) begin lvl_n = m_s2; dcnt_n = 0; end
        else dcnt_n = m_dcnt + 1;
      end
      st_n = m_st; pcnt_n = m_pcnt; eo_s = 0; spo_s = 0;
      if (force_off) begin st_n = 1; pcnt_n = 0; end
      else if (m_st == 0) begin
        if (!pr) pcnt_n = 0;
        else if (m_pcnt >= ms_of(1, on_sel)) begin st_n = 2; pcnt_n = 0; end
        else if (tick) pcnt_n = m_pcnt + 1;
      end else if (m_st == 1) begin
        pcnt_n = 0; if (!pr) st_n = 0;
      end else if (m_st == 2) begin
        pcnt_n = 0; if (!pr) st_n = 3;
      end else begin
        if (!pr) begin pcnt_n = 0; spo_s = m_held; end
        else if (lp_sel != 3 && m_pcnt >= ms_of(2, lp_sel)) begin
          st_n = 1; pcnt_n = 0; eo_s = 1;
        end else if (tick) pcnt_n = m_pcnt + 1;
      end
      m_held = (m_st == 3 && pr && st_n == 3);
      m_bi  = (m_bi && !flag_clr[0]) || ev;
      m_eo  = (m_eo && !flag_clr[1]) || eo_s;
      m_spo = (m_spo && !flag_clr[2]) || spo_s;
      m_lq = m_lvl; m_lvl = lvl_n; m_dcnt = dcnt_n;
      m_s2 = m_s1; m_s1 = btn_i;
      m_st = st_n; m_pcnt = pcnt_n;
    end
    #5;
    if (rst_n && !done) begin
      int on;
      on = (m_st >= 2);
      chk("R1 level", btn_level_o, m_lvl);
      chk("R3 bi flag", flag_bi_o, m_bi);
      chk("R3 irq", irq_o, m_bi && irq_en);
      chk("R5 eo flag", flag_eo_o, m_eo);
      chk("R6 spo flag", flag_spo_o, m_spo);
      chk("R8 pwr_req", pwr_req_o, !force_off && (req_ovr || (req_en && on)));
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear(input logic [2:0] bits);
    @(negedge clk) flag_clr = bits;
    @(negedge clk) flag_clr = 3'd0;
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(2);
    chk("R10 req after reset", pwr_req_o, 0);
    chk("R10 flags after reset", {flag_bi_o, flag_eo_o, flag_spo_o}, 0);
    chk("R10 level after reset", btn_level_o, 0);

    btn_i = 1; wait_cyc(10);
    chk("R4 immediate turn-on", pwr_req_o, 1);
    chk("R2 active-high sets flag", flag_bi_o, 1);
    btn_i = 0; wait_cyc(6); clear(3'b001); wait_cyc(2);
    chk("R9 clear bi", flag_bi_o, 0);

    btn_i = 1; wait_cyc(50); btn_i = 0; wait_cyc(10);
    chk("R6 short press spo", flag_spo_o, 1);
    chk("R6 power kept", pwr_req_o, 1);

    db_sel = 2'd0; wait_cyc(5);
    btn_i = 1; wait_cyc(20); btn_i = 0; wait_cyc(100);
    chk("R1 glitch filtered", btn_level_o, 0);

    lp_sel = 2'd0;
    btn_i = 1; wait_cyc(7000);
    chk("R5 emergency off flag", flag_eo_o, 1);
    chk("R5 power dropped", pwr_req_o, 0);
    btn_i = 0; wait_cyc(200);

    db_sel = 2'd3; on_sel = 2'd1; wait_cyc(5);
    btn_i = 1; wait_cyc(30); btn_i = 0; wait_cyc(10);
    chk("R4 short press stays off", pwr_req_o, 0);
    btn_i = 1; wait_cyc(100);
    chk("R4 50ms press turns on", pwr_req_o, 1);
    btn_i = 0; wait_cyc(10);

    lp_sel = 2'd3; clear(3'b110);
    btn_i = 1; wait_cyc(21000);
    chk("R5 disabled long press keeps power", pwr_req_o, 1);
    chk("R5 disabled no eo", flag_eo_o, 0);
    btn_i = 0; wait_cyc(10);

    force_off = 1; wait_cyc(3);
    chk("R7 force off", pwr_req_o, 0);
    force_off = 0; wait_cyc(5);
    chk("R7 stays off after force", pwr_req_o, 0);

    req_ovr = 1; wait_cyc(2);
    chk("R8 override", pwr_req_o, 1);
    req_ovr = 0; on_sel = 2'd3;
    btn_i = 1; wait_cyc(10); btn_i = 0; wait_cyc(10);
    chk("R4 turned on again", pwr_req_o, 1);
    req_en = 0; wait_cyc(2);
    chk("R8 enable gates request", pwr_req_o, 0);
    req_en = 1; wait_cyc(2);

    force_off = 1; wait_cyc(3);
    trig_sel = 3'd2; clear(3'b111); wait_cyc(2);
    btn_i = 1; wait_cyc(6);
    chk("R2 rising edge sets flag", flag_bi_o, 1);
    clear(3'b001); wait_cyc(5);
    chk("R2 rising edge fires once", flag_bi_o, 0);
    btn_i = 0; wait_cyc(6);
    chk("R2 rising mode ignores fall", flag_bi_o, 0);
    trig_sel = 3'd3; btn_i = 1; wait_cyc(6);
    chk("R2 falling mode ignores rise", flag_bi_o, 0);
    btn_i = 0; wait_cyc(6);
    chk("R2 falling edge sets flag", flag_bi_o, 1);
    trig_sel = 3'd4; clear(3'b001); btn_i = 1; wait_cyc(6);
    chk("R2 any edge rise", flag_bi_o, 1);
    clear(3'b001); btn_i = 0; wait_cyc(6);
    chk("R2 any edge fall", flag_bi_o, 1);
    irq_en = 0; wait_cyc(2);
    chk("R3 irq masked", irq_o, 0);
    irq_en = 1; wait_cyc(2);
    chk("R3 irq enabled", irq_o, 1);
    trig_sel = 3'd0; clear(3'b001); wait_cyc(2);
    chk("R9 set wins over clear", flag_bi_o, 1);
    chk("R7 active-low press held off", pwr_req_o, 0);
    wait_cyc(5);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule